// File: doc/BRIEF.md
# Indexed Colour Palette with Sequenced Component Writes

This block holds the colour palette of an 8-bit indexed frame buffer. Software programs it through a small 32-bit register window that has two live registers. One register selects the palette entry. The other receives the colour components of that entry, one write at a time. Only the most significant byte of each bus word carries the value. A phase counter decides whether a component write lands in the red, green or blue table. The counter wraps after blue. The selected entry stays where it is, so a further triplet rewrites the same colour unless a new entry number is loaded first.

The display side presents one pixel code per clock on a separate port. It receives the 24-bit colour one cycle later. Each of the three component tables is a simple dual-port memory: one write port driven by the sequencer and one registered read port driven by the pixel code. This lets the tables map onto block RAM. Bus reads of the window always return zero.

Top module: `palette_dac`

## Requirements
- R1: The register is chosen by address bits 3:2 of the 4-bit byte address. Word 0 is the entry select and word 1 is the component data.
- R2: A write to word 0 loads the entry number from data bits 31:24 and sets the component phase back to red.
- R3: A write to word 1 stores data bits 31:24 in the table picked by the phase (red, green or blue) at the current entry.
- R4: The phase steps red, green, blue and then returns to red after the blue write. It never takes any other value.
- R5: The entry number does not change after a component write, so a second triplet overwrites the same entry.
- R6: Writes to words 2 and 3 change neither the entry number, the phase nor any table contents.
- R7: The bus read data output is zero at all times.
- R8: Reset clears the entry number and the phase to zero and drives the colour output to zero.
- R9: The colour output is registered. It shows red in bits 23:16, green in bits 15:8 and blue in bits 7:0 for the pixel code presented one clock earlier.
- R10: When a component write and a pixel lookup hit the same entry in the same cycle, the lookup returns the colour held before the write.
- R11: Address bits 1:0 and data bits 23:0 have no effect on any write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the register window |
| bus_addr | input | 4 | Byte address within the window |
| bus_wdata | input | 32 | Write data; the value is in bits 31:24 |
| bus_rdata | output | 32 | Read data, always zero |
| pix_code | input | 8 | Pixel code to translate |
| rgb_out | output | 24 | Registered colour {red, green, blue} |

## Verification
The entry number and the phase cannot be observed at the ports. Their effect only appears when a later component write lands somewhere and a lookup of that entry shows it. The hardest case is proving that an ignored write or a reset in the middle of a triplet left the hidden phase exactly where the rules say. To reach it, the stimulus interrupts triplets partway through, with writes to the unused words, reloads of the entry register and a reset. It then completes the triplet and looks up both the intended entry and its neighbours. The same-cycle write-and-lookup collision is driven by pointing the pixel code at the entry under write during each component write.

// File: rtl/pdac_pkg.sv
package pdac_pkg;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  localparam int NUM_COMP = 3;

  localparam logic [1:0] WORD_SELECT = 2'd0;
  localparam logic [1:0] WORD_COLOUR = 2'd1;

  function automatic phase_e phase_next(input phase_e cur);
    case (cur)
      PH_RED:  phase_next = PH_GRN;
      PH_GRN:  phase_next = PH_BLU;
      default: phase_next = PH_RED;
    endcase
  endfunction

endpackage

// File: rtl/pdac_decode.sv
module pdac_decode #(
  parameter int ADDR_W = 4
) (
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              sel_wr,
  output logic              col_wr
);
  import pdac_pkg::*;

  logic [1:0] word;

  // word index comes from byte address bits 3:2
  assign word   = bus_addr[3:2];
  assign sel_wr = bus_we && (word == WORD_SELECT);
  assign col_wr = bus_we && (word == WORD_COLOUR);

endmodule

// File: rtl/pdac_seq.sv
module pdac_seq #(
  parameter int IDX_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          sel_wr,
  input  logic                          col_wr,
  input  logic [IDX_W-1:0]              sel_val,
  output logic [IDX_W-1:0]              cur_idx,
  output pdac_pkg::phase_e              phase_q,
  output logic [pdac_pkg::NUM_COMP-1:0] comp_we
);
  import pdac_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_idx <= '0;
      phase_q <= PH_RED;
    end else if (sel_wr) begin
      cur_idx <= sel_val;
      phase_q <= PH_RED;
    end else if (col_wr) begin
      phase_q <= phase_next(phase_q);
    end
  end

  for (genvar k = 0; k < NUM_COMP; k++) begin : g_we
    assign comp_we[k] = col_wr && (phase_q == phase_e'(k));
  end

endmodule

// File: rtl/pdac_table.sv
module pdac_table #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [COMP_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [COMP_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [COMP_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // read-before-write: a colliding lookup sees the old entry
  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end

endmodule

// File: rtl/palette_dac.sv
module palette_dac #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_we,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  input  logic [IDX_W-1:0]         pix_code,
  output logic [3*COMP_W-1:0]      rgb_out
);
  import pdac_pkg::*;

  localparam int VAL_LSB = DATA_W - COMP_W;

  logic                 sel_wr;
  logic                 col_wr;
  logic [IDX_W-1:0]     cur_idx;
  phase_e               phase_q;
  logic [NUM_COMP-1:0]  comp_we;
  logic [COMP_W-1:0]    wr_val;
  logic                 unused_bits;

  assign wr_val      = bus_wdata[DATA_W-1 -: COMP_W];
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[VAL_LSB-1:0]};
  assign bus_rdata   = '0;

  pdac_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_we  (bus_we),
    .bus_addr(bus_addr),
    .sel_wr  (sel_wr),
    .col_wr  (col_wr)
  );

  pdac_seq #(.IDX_W(IDX_W)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .sel_wr (sel_wr),
    .col_wr (col_wr),
    .sel_val(bus_wdata[DATA_W-1 -: IDX_W]),
    .cur_idx(cur_idx),
    .phase_q(phase_q),
    .comp_we(comp_we)
  );

  for (genvar g = 0; g < NUM_COMP; g++) begin : g_tbl
    pdac_table #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_tbl (
      .clk  (clk),
      .rst  (rst),
      .we   (comp_we[g]),
      .waddr(cur_idx),
      .wdata(wr_val),
      .raddr(pix_code),
      .rdata(rgb_out[(NUM_COMP-1-g)*COMP_W +: COMP_W])
    );
  end

endmodule

// File: rtl/pdac_checker.sv
module pdac_checker #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [IDX_W-1:0]  cur_idx,
  input logic [1:0]        phase
);
  logic [1:0] word;
  assign word = bus_addr[3:2];

  assert_select_load_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && word == 2'd0) |=>
      (cur_idx == $past(bus_wdata[DATA_W-1 -: IDX_W]) && phase == 2'd0));

  assert_phase_step_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_we && word == 2'd1) |=>
      (phase == (($past(phase) == 2'd2) ? 2'd0 : $past(phase) + 2'd1)));

  assert_phase_legal_R4: assert property (@(posedge clk) disable iff (rst)
    phase != 2'd3);

  assert_no_autoinc_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_we && word == 2'd1) |=> $stable(cur_idx));

  assert_ignored_words_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_we && word[1]) |=> ($stable(cur_idx) && $stable(phase)));

  assert_reset_clear_R8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cur_idx == '0 && phase == 2'd0));

endmodule

bind palette_dac pdac_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .cur_idx  (cur_idx),
  .phase    (phase_q)
);

// File: tb/palette_dac_test.sv
`timescale 1ns/1ps
module palette_dac_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pix_code = '0;
  logic [23:0] rgb_out;

  always #2 clk = ~clk;

  palette_dac uut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pix_code(pix_code), .rgb_out(rgb_out)
  );

  // reference model
  logic [7:0] ref_r [256];
  logic [7:0] ref_g [256];
  logic [7:0] ref_b [256];
  int ref_idx = 0;
  int ref_ph  = 0;

  int errors = 0;
  int checks = 0;
  string cur_req = "R8";
  bit done = 0;

  task automatic step(input logic r, input logic we, input logic [3:0] a,
                      input logic [31:0] d, input logic [7:0] p);
    logic [23:0] exp_rgb;
    bus_we = we; bus_addr = a; bus_wdata = d; pix_code = p; rst = r;
    exp_rgb = r ? 24'h0 : {ref_r[p], ref_g[p], ref_b[p]};
    if (r) begin
      ref_idx = 0; ref_ph = 0;
    end else if (we) begin
      if (a[3:2] == 2'd0) begin
        ref_idx = int'(d[31:24]); ref_ph = 0;
      end else if (a[3:2] == 2'd1) begin
        case (ref_ph)
          0: ref_r[ref_idx] = d[31:24];
          1: ref_g[ref_idx] = d[31:24];
          default: ref_b[ref_idx] = d[31:24];
        endcase
        ref_ph = (ref_ph + 1) % 3;
      end
    end
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (rgb_out !== exp_rgb) begin
      errors++;
      $display("FAIL %s: pixel %0d rgb actual %06h expected %06h", cur_req, p, rgb_out, exp_rgb);
    end
    checks++;
    if (bus_rdata !== 32'h0) begin
      errors++;
      $display("FAIL R7: read data actual %08h expected 00000000", bus_rdata);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] v, input logic [7:0] p);
    step(1'b0, 1'b1, a, {v, 24'hA5C3E1}, p);
  endtask

  task automatic look(input logic [7:0] p);
    step(1'b0, 1'b0, 4'h0, 32'h0, p);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      ref_r[i] = 8'h0; ref_g[i] = 8'h0; ref_b[i] = 8'h0;
    end
    @(negedge clk);
    // R8: reset state, then triplet lands at entry 0 with no select write
    cur_req = "R8";
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 4'h0, 32'h0, 8'h0);
    wr(4'h4, 8'h11, 8'h0);
    wr(4'h4, 8'h22, 8'h0);
    wr(4'h4, 8'h33, 8'h0);
    look(8'h0);

    // R3: fill every entry
    cur_req = "R3";
    for (int i = 1; i < 256; i++) begin
      wr(4'h0, 8'(i), 8'(i - 1));
      wr(4'h4, 8'(i) ^ 8'h5A, 8'(i));
      wr(4'h4, 8'(i + 7), 8'(255 - i));
      wr(4'h4, ~8'(i), 8'(i * 3));
    end

    // R9: lookup sweep, one code per cycle
    cur_req = "R9";
    for (int i = 0; i < 256; i++) look(8'(i * 7 + 1));

    // R5: two triplets on the same entry, neighbour untouched
    cur_req = "R5";
    wr(4'h0, 8'd9, 8'd9);
    for (int i = 0; i < 6; i++) wr(4'h4, 8'(8'hC0 + i), 8'd10);
    look(8'd9); look(8'd10); look(8'd8);

    // R2: select write mid-triplet restarts at red
    cur_req = "R2";
    wr(4'h0, 8'd20, 8'd20);
    wr(4'h4, 8'h77, 8'd20);
    wr(4'h0, 8'd21, 8'd20);
    wr(4'h4, 8'h88, 8'd21);
    look(8'd20); look(8'd21);

    // R6: writes to words 2 and 3 are ignored
    cur_req = "R6";
    wr(4'h0, 8'd30, 8'd30);
    wr(4'h4, 8'h01, 8'd30);
    wr(4'h8, 8'd31, 8'd31);
    wr(4'hC, 8'd32, 8'd32);
    wr(4'hB, 8'h99, 8'd30);
    wr(4'h4, 8'h02, 8'd30);
    wr(4'h4, 8'h03, 8'd31);
    look(8'd30); look(8'd31); look(8'd32);

    // R1 / R11: low address bits and low data bits ignored
    cur_req = "R11";
    wr(4'h3, 8'd40, 8'd40);
    wr(4'h5, 8'hAB, 8'd40);
    wr(4'h6, 8'hCD, 8'd40);
    wr(4'h7, 8'hEF, 8'd40);
    cur_req = "R1";
    look(8'd40); look(8'd41);
    step(1'b0, 1'b1, 4'h1, 32'h32FFFFFF, 8'd50);
    step(1'b0, 1'b1, 4'h4, 32'h44000000, 8'd50);
    look(8'd50);

    // R10: write and lookup on the same entry in the same cycle
    cur_req = "R10";
    wr(4'h0, 8'd60, 8'd60);
    wr(4'h4, 8'h5E, 8'd60);
    look(8'd60);
    wr(4'h4, 8'h6F, 8'd60);
    wr(4'h4, 8'h70, 8'd60);
    look(8'd60);

    // R4: several complete triplets cycle the phase cleanly
    cur_req = "R4";
    wr(4'h0, 8'd70, 8'd70);
    for (int i = 0; i < 9; i++) wr(4'h4, 8'(i * 17), 8'd70);
    look(8'd70);

    // R8: reset mid-triplet returns to entry 0, red
    cur_req = "R8";
    wr(4'h0, 8'd80, 8'd80);
    wr(4'h4, 8'h12, 8'd80);
    step(1'b1, 1'b0, 4'h0, 32'h0, 8'd80);
    wr(4'h4, 8'hD1, 8'd0);
    wr(4'h4, 8'hD2, 8'd80);
    look(8'd0); look(8'd80);

    // R7: reads flagged on every step; final sweep
    cur_req = "R7";
    for (int i = 0; i < 64; i++) look(8'(i * 5));

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule